// File: doc/BRIEF.md
# Segment-Map Address Translator

This block turns a 32-bit virtual address into a physical page address in two table lookups, using memories on the chip. The current context and a field of segment bits from the address index a segment map. The segment map returns a page-group number. That group number, combined with six page bits from the address, selects one 32-bit page entry. The entry supplies the frame number, the cache-inhibit flag, the space type and the permission bits. It also holds referenced and modified status, which the block updates itself on every successful access.

A requester presents an address with write and user-mode qualifiers on a valid/ready handshake. The requester receives the physical address, the cache-inhibit flag, the space type and a fault code on the following pipeline output. A separate control port lets software load and inspect the segment map, the page entries and the context register. Address regions whose top three bits are mixed are not mapped at all and fault at once.

The default parameters build a reduced geometry: 8 contexts, 32 segments per context and 16 page groups. The full-size form uses a 12-bit segment field and a 7-bit group number.

Top module: `segmap_xlat`

## Requirements
- R1: When req_va[31:29] is neither 000 nor 111, the response carries fault code 1 (hole), and no page entry changes.
- R2: The segment map is indexed by {context, req_va[18+SEG_W-1:18]}, with the context in the upper bits. It yields the page-group number used for that request.
- R3: The page entry is selected by {group, req_va[17:12]}, with the group in the upper bits. Page-entry control-port addresses use the same packing.
- R4: Page entry bit 31 is valid, bit 30 is writable and bit 29 is supervisor-only. When the address is outside the hole, the fault code is chosen in this priority order: 2 for an invalid entry, then 3 for a user access to a supervisor-only entry, then 4 for a write to a non-writable entry. Otherwise the code is 0.
- R5: On fault code 0, the stored entry gets bit 25 (referenced) set. On a write it also gets bit 24 (modified) set. All other bits are kept. Any nonzero fault leaves the entry unchanged.
- R6: On fault code 0, rsp_pa equals {entry[FRAME_W-1:0], req_va[11:0]}. rsp_nocache equals entry bit 28. rsp_space equals entry bits 27:26, where 00 is board memory, 01 is board I/O, 10 is 16-bit VME and 11 is 32-bit VME.
- R7: req_ready is always high, so one request can be accepted every cycle. A request accepted at clock edge n is reported with rsp_valid high after edge n+1, for one cycle.
- R8: On the control port, a cycle with sw_req high does one of two things. With sw_we high, it writes the target: sw_tgt 0 is the segment map, 1 is a page entry and 2 is the context register. With sw_we low, it loads sw_rdata, zero-extended, at that edge. Page-entry bits 23:16 are stored and read back, but they never affect translation.
- R9: A control write to a page entry wins over a hardware status write-back to the same entry in the same cycle.
- R10: After reset, rsp_valid is low and the context register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | FRAME_W+12 | Physical address |
| rsp_nocache | output | 1 | Cache must be bypassed |
| rsp_space | output | 2 | Space type from the entry |
| rsp_fault | output | 3 | Fault code (0 = none) |
| sw_req | input | 1 | Control access strobe |
| sw_we | input | 1 | Control access is a write |
| sw_tgt | input | 2 | Control target select |
| sw_addr | input | SWA_W | Segment-map index or page-entry address |
| sw_wdata | input | 32 | Control write data |
| sw_rdata | output | 32 | Control read data |

## Verification
The hardest situation to reach is a control write that lands in the same cycle as the status write-back of an in-flight translation to the same entry. The bench reaches it by issuing a write translation and then driving the control write in the very next cycle, when the entry read and the write-back happen. It then reads the entry back and expects the software value. A twin sequence aimed at a different entry shows that the write-back still happens when there is no clash. A two-pass sweep over every context and segment, with mixed write and user flags, revisits entries. This makes referenced and modified bits accumulate, and a final readback of all page entries compares them with the bench's model.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_HOLE    = 3'd1,
    FLT_INVALID = 3'd2,
    FLT_PRIV    = 3'd3,
    FLT_WRITE   = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    TGT_SEGMAP = 2'd0,
    TGT_PTE    = 2'd1,
    TGT_CTX    = 2'd2
  } tgt_e;

  localparam int unsigned B_VALID   = 31;
  localparam int unsigned B_WRITE   = 30;
  localparam int unsigned B_SUPER   = 29;
  localparam int unsigned B_NOCACHE = 28;
  localparam int unsigned B_SPC_LO  = 26;
  localparam int unsigned B_REF     = 25;
  localparam int unsigned B_MOD     = 24;
  localparam int unsigned OFF_W     = 12;
  localparam int unsigned PIDX_W    = 6;

  // Top three address bits must agree, otherwise the address is unmapped.
  function automatic logic va_in_hole(input logic [31:0] va);
    return !(va[31:29] == 3'b000 || va[31:29] == 3'b111);
  endfunction

  // Fault decision in priority order.
  function automatic fault_e judge(input logic hole, input logic [31:0] ent,
                                   input logic user, input logic wr);
    if (hole) return FLT_HOLE;
    if (!ent[B_VALID]) return FLT_INVALID;
    if (user && ent[B_SUPER]) return FLT_PRIV;
    if (wr && !ent[B_WRITE]) return FLT_WRITE;
    return FLT_NONE;
  endfunction

  // Status update applied on a successful access.
  function automatic logic [31:0] mark_used(input logic [31:0] ent, input logic wr);
    logic [31:0] r;
    r = ent;
    r[B_REF] = 1'b1;
    if (wr) r[B_MOD] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/xlat_segmap.sv
module xlat_segmap #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned GRP_W = 4
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [GRP_W-1:0] lk_grp,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic [GRP_W-1:0] sw_grp,
  output logic [GRP_W-1:0] sw_rd
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [GRP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (sw_we) mem[sw_idx] <= sw_grp;
  end

  assign lk_grp = mem[lk_idx];
  assign sw_rd  = mem[sw_idx];
endmodule

// File: rtl/xlat_pte_ram.sv
module xlat_pte_ram #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] lk_addr,
  output logic [31:0]   lk_ent,
  input  logic          wb_en,
  input  logic [31:0]   wb_data,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rd
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];
  logic        wb_collide;

  assign wb_collide = wb_en && sw_we && (sw_addr == lk_addr);

  always_ff @(posedge clk) begin
    if (wb_en && !wb_collide) mem[lk_addr] <= wb_data;
    if (sw_we) mem[sw_addr] <= sw_wdata;
  end

  assign lk_ent = mem[lk_addr];
  assign sw_rd  = mem[sw_addr];

  // R9
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_collide |=> mem[$past(sw_addr)] == $past(sw_wdata));

  // R5
  wb_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !sw_we) |=> mem[$past(lk_addr)] == $past(wb_data));
endmodule

// File: rtl/segmap_xlat.sv
module segmap_xlat
  import xlat_pkg::*;
#(
  parameter int unsigned CTX_W   = 3,
  parameter int unsigned SEG_W   = 5,
  parameter int unsigned GRP_W   = 4,
  parameter int unsigned FRAME_W = 16,
  localparam int unsigned SIDX_W = CTX_W + SEG_W,
  localparam int unsigned PAW    = GRP_W + 6,
  localparam int unsigned PA_W   = FRAME_W + 12,
  localparam int unsigned SWA_W  = (SIDX_W > PAW) ? SIDX_W : PAW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_va,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_nocache,
  output logic [1:0]       rsp_space,
  output logic [2:0]       rsp_fault,
  input  logic             sw_req,
  input  logic             sw_we,
  input  logic [1:0]       sw_tgt,
  input  logic [SWA_W-1:0] sw_addr,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata
);
  // Named internal events
  logic              accept;
  logic              sw_wr_seg, sw_wr_pte, sw_wr_ctx, sw_rd_any;
  logic [CTX_W-1:0]  ctx_q;
  logic [SIDX_W-1:0] lk_idx;
  logic [GRP_W-1:0]  lk_grp, sw_rd_grp;
  logic [31:0]       lk_ent, sw_rd_ent, wb_data;
  logic [PAW-1:0]    pte_addr;
  logic              wb_en;
  fault_e            fault;
  logic              unused_va;

  // Stage 1: segment map result and request qualifiers
  logic              s1_vld, s1_hole, s1_wr, s1_user;
  logic [GRP_W-1:0]  s1_grp;
  logic [PIDX_W-1:0] s1_pidx;
  logic [OFF_W-1:0]  s1_off;

  assign req_ready = 1'b1;
  assign accept    = req_valid && req_ready;
  assign unused_va = ^req_va;
  assign lk_idx    = {ctx_q, req_va[18 +: SEG_W]};

  assign sw_wr_seg = sw_req && sw_we && (sw_tgt == TGT_SEGMAP);
  assign sw_wr_pte = sw_req && sw_we && (sw_tgt == TGT_PTE);
  assign sw_wr_ctx = sw_req && sw_we && (sw_tgt == TGT_CTX);
  assign sw_rd_any = sw_req && !sw_we;

  xlat_segmap #(.IDX_W(SIDX_W), .GRP_W(GRP_W)) i_segmap (
    .clk    (clk),
    .lk_idx (lk_idx),
    .lk_grp (lk_grp),
    .sw_we  (sw_wr_seg),
    .sw_idx (sw_addr[SIDX_W-1:0]),
    .sw_grp (sw_wdata[GRP_W-1:0]),
    .sw_rd  (sw_rd_grp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_hole <= 1'b0;
      s1_wr   <= 1'b0;
      s1_user <= 1'b0;
      s1_grp  <= '0;
      s1_pidx <= '0;
      s1_off  <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_hole <= va_in_hole(req_va);
        s1_wr   <= req_write;
        s1_user <= req_user;
        s1_grp  <= lk_grp;
        s1_pidx <= req_va[OFF_W +: PIDX_W];
        s1_off  <= req_va[OFF_W-1:0];
      end
    end
  end

  // Stage 2: page entry read, check, status write-back
  assign pte_addr = {s1_grp, s1_pidx};
  assign fault    = judge(s1_hole, lk_ent, s1_user, s1_wr);
  assign wb_en    = s1_vld && (fault == FLT_NONE);
  assign wb_data  = mark_used(lk_ent, s1_wr);

  xlat_pte_ram #(.AW(PAW)) i_pte_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_addr  (pte_addr),
    .lk_ent   (lk_ent),
    .wb_en    (wb_en),
    .wb_data  (wb_data),
    .sw_we    (sw_wr_pte),
    .sw_addr  (sw_addr[PAW-1:0]),
    .sw_wdata (sw_wdata),
    .sw_rd    (sw_rd_ent)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_pa      <= '0;
      rsp_nocache <= 1'b0;
      rsp_space   <= '0;
      rsp_fault   <= FLT_NONE;
    end else begin
      rsp_valid <= s1_vld;
      if (s1_vld) begin
        rsp_pa      <= {lk_ent[FRAME_W-1:0], s1_off};
        rsp_nocache <= lk_ent[B_NOCACHE];
        rsp_space   <= lk_ent[B_SPC_LO +: 2];
        rsp_fault   <= fault;
      end
    end
  end

  // Control port: context register and read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q    <= '0;
      sw_rdata <= '0;
    end else begin
      if (sw_wr_ctx) ctx_q <= sw_wdata[CTX_W-1:0];
      if (sw_rd_any) begin
        case (sw_tgt)
          TGT_SEGMAP: sw_rdata <= 32'(sw_rd_grp);
          TGT_PTE:    sw_rdata <= sw_rd_ent;
          TGT_CTX:    sw_rdata <= 32'(ctx_q);
          default:    sw_rdata <= '0;
        endcase
      end
    end
  end

  // R7
  stage_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> s1_vld);
  // R7
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> rsp_valid);
  // R1
  hole_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(s1_hole)) |-> rsp_fault == FLT_HOLE);
  // R4
  clean_needs_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |->
      ($past(lk_ent[B_VALID]) && !($past(s1_user) && $past(lk_ent[B_SUPER]))));
  // R6
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> rsp_pa[OFF_W-1:0] == $past(s1_off));
endmodule

// File: tb/test_segmap_xlat.sv
module test_segmap_xlat;
  localparam int CLK_P = 10;
  localparam int CTX_W = 3;
  localparam int SEG_W = 5;
  localparam int GRP_W = 4;
  localparam int NSEG  = 1 << (CTX_W + SEG_W);
  localparam int NPTE  = 1 << (GRP_W + 6);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid, rsp_nocache;
  logic [27:0] rsp_pa;
  logic [1:0]  rsp_space;
  logic [2:0]  rsp_fault;
  logic        sw_req = 1'b0, sw_we = 1'b0;
  logic [1:0]  sw_tgt = '0;
  logic [9:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [GRP_W-1:0] seg_m [NSEG];
  logic [31:0]      pte_m [NPTE];

  always #(CLK_P/2) clk = ~clk;

  segmap_xlat #(.CTX_W(CTX_W), .SEG_W(SEG_W), .GRP_W(GRP_W), .FRAME_W(16)) i_segmap_xlat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_nocache(rsp_nocache),
    .rsp_space(rsp_space), .rsp_fault(rsp_fault), .sw_req(sw_req), .sw_we(sw_we),
    .sw_tgt(sw_tgt), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic sw_write(input logic [1:0] t, input int a, input logic [31:0] d);
    sw_req = 1'b1; sw_we = 1'b1; sw_tgt = t; sw_addr = 10'(a); sw_wdata = d;
    @(negedge clk);
    sw_req = 1'b0; sw_we = 1'b0;
  endtask

  task automatic sw_read(input logic [1:0] t, input int a, output logic [31:0] d);
    sw_req = 1'b1; sw_we = 1'b0; sw_tgt = t; sw_addr = 10'(a);
    @(negedge clk);
    sw_req = 1'b0;
    d = sw_rdata;
  endtask

  task automatic issue(input logic [31:0] va, input logic wr, input logic usr);
    req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected 0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd, lcg;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    sw_read(2'd2, 0, rd);
    chk("R10 context after reset", 64'(rd), 64'd0);
    chk("R7 ready", 64'(req_ready), 64'd1);

    // Load tables (R8)
    for (int i = 0; i < NSEG; i++) begin
      seg_m[i] = GRP_W'((i * 5 + 3) % (1 << GRP_W));
      sw_write(2'd0, i, 32'(seg_m[i]));
    end
    lcg = 32'h1234_5678;
    for (int i = 0; i < NPTE; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      pte_m[i] = lcg & ~32'h0300_0000;
      sw_write(2'd1, i, pte_m[i]);
    end
    for (int i = 0; i < NSEG; i++) begin
      sw_read(2'd0, i, rd);
      chk("R8 segment map readback", 64'(rd), 64'(seg_m[i]));
    end

    // Sweep: two passes over every context and segment
    for (int pass = 0; pass < 2; pass++) begin
      for (int c = 0; c < (1 << CTX_W); c++) begin
        sw_write(2'd2, c, 32'(c));
        sw_read(2'd2, 0, rd);
        chk("R8 context readback", 64'(rd), 64'(c));
        for (int s = 0; s < (1 << SEG_W); s++) begin
          int k, pi, off, g, e, exf;
          logic [2:0] top;
          logic [31:0] va, ent;
          logic wr, usr, hole;
          k   = pass * NSEG + c * (1 << SEG_W) + s;
          top = (k % 6 == 5) ? ((k % 12 == 5) ? 3'b010 : 3'b101)
                             : ((k % 2 == 1) ? 3'b111 : 3'b000);
          pi  = (k * 13) % 64;
          off = (k * 37) % 4096;
          va  = 32'(k) * 32'd2654435761;
          va[31:29] = top;
          va[18 +: SEG_W] = SEG_W'(s);
          va[17:12] = 6'(pi);
          va[11:0]  = 12'(off);
          wr  = k[1];
          usr = k[2] ^ k[0];
          hole = (top != 3'b000) && (top != 3'b111);
          g   = int'(seg_m[c * (1 << SEG_W) + s]);
          e   = g * 64 + pi;
          ent = pte_m[e];
          if (hole) exf = 1;
          else if (!ent[31]) exf = 2;
          else if (usr && ent[29]) exf = 3;
          else if (wr && !ent[30]) exf = 4;
          else exf = 0;
          issue(va, wr, usr);
          chk("R7 response valid", 64'(rsp_valid), 64'd1);
          chk(hole ? "R1 hole fault" : "R4 fault code", 64'(rsp_fault), 64'(exf));
          if (exf == 0) begin
            chk("R2 R3 R6 pa nocache space", {rsp_pa, rsp_nocache, rsp_space},
                {ent[15:0], va[11:0], ent[28], ent[27:26]});
            pte_m[e] = ent | 32'h0200_0000 | (wr ? 32'h0100_0000 : 32'h0);
          end
        end
      end
    end
    for (int i = 0; i < NPTE; i++) begin
      sw_read(2'd1, i, rd);
      chk("R5 R8 page entry after sweep", 64'(rd), 64'(pte_m[i]));
    end

    // Back-to-back requests to one entry: context 0, segment 0 -> group seg_m[0]
    begin
      int e2;
      e2 = int'(seg_m[0]) * 64 + 5;
      sw_write(2'd2, 0, 32'd0);
      sw_write(2'd1, e2, 32'hC000_0055);
      req_valid = 1'b1; req_va = 32'h0000_5ABC; req_write = 1'b1; req_user = 1'b1;
      @(negedge clk);
      req_va = 32'h0000_5123; req_write = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 first of pair", {rsp_valid, rsp_fault, rsp_pa}, {1'b1, 3'd0, 28'h0055ABC});
      @(negedge clk);
      chk("R7 second of pair", {rsp_valid, rsp_fault, rsp_pa}, {1'b1, 3'd0, 28'h0055123});
      @(negedge clk);
      chk("R7 pipeline empty", 64'(rsp_valid), 64'd0);
      sw_read(2'd1, e2, rd);
      chk("R5 status after pair", 64'(rd), 64'h0000_0000_C300_0055);
    end

    // Collision: control write in the write-back cycle, same entry and other entry
    for (int same = 0; same < 2; same++) begin
      int e3, e4;
      e3 = int'(seg_m[0]) * 64 + 9;
      e4 = int'(seg_m[0]) * 64 + 10;
      sw_write(2'd1, e3, 32'hC000_1234);
      sw_write(2'd1, e4, 32'h8000_0000);
      req_valid = 1'b1; req_va = 32'h0000_9010; req_write = 1'b1; req_user = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      sw_req = 1'b1; sw_we = 1'b1; sw_tgt = 2'd1;
      sw_addr = 10'(same == 1 ? e3 : e4); sw_wdata = 32'h8000_ABCD;
      @(negedge clk);
      sw_req = 1'b0; sw_we = 1'b0;
      chk("R9 translation during clash", {rsp_valid, rsp_fault, rsp_pa},
          {1'b1, 3'd0, 28'h1234010});
      sw_read(2'd1, e3, rd);
      if (same == 1) chk("R9 control write wins", 64'(rd), 64'h8000_ABCD);
      else chk("R9 write-back without clash", 64'(rd), 64'hC300_1234);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule